// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a small data cache for a processor load/store port. Its main store is a direct-mapped array of 32-byte lines. Beside it sits a four-entry, fully associative victim buffer. When a line in the main array is replaced by a fill, the old line moves into the victim buffer instead of being dropped. If a later read misses the main array but matches a buffer entry, the buffer line and the line now in that main-array slot trade places. The requested word is returned one cycle later, and no lower-level access is made.

A read that misses in both stores requests the whole line from the lower level and installs it. Writes are write-through without allocate. A write that finds the line in either store updates that copy. Every write is also forwarded to the lower level as a single word, and the write completes when the lower level acknowledges it.

The processor holds a request until the cycle in which `cpu_ready_o` is high. The lower level sees a request that is held until it answers with an acknowledge. For a read, that acknowledge cycle also carries the full line.

Top module: `vcache_top`

## Requirements
- R1: After reset, every line in both the main array and the victim buffer is invalid. The first read of any address is therefore a miss that goes to the lower level. With no request pending, `cpu_ready_o`, `cpu_stall_o` and `mem_req_o` are low.
- R2: The address is split as follows: bits [4:2] select the 32-bit word within the line, bits [9:5] select the main-array slot, and bits [31:10] are the stored tag. A fill request puts the line-aligned address on `mem_addr_o`, with bits [4:0] equal to zero.
- R3: A read that hits the main array completes in its request cycle. `cpu_ready_o` and `cpu_hit_o` are high, `cpu_rdata_o` carries the word, and no lower-level request is made.
- R4: A read that misses both stores raises `mem_req_o` with `mem_we_o` low. The request is held steady until `mem_ack_i`. In the acknowledge cycle the block returns the requested word from `mem_rdata_i`, with `cpu_ready_o` high and `cpu_hit_o` low. The line is then installed in the main array, so a repeated read hits.
- R5: A valid main-array line that is replaced by a fill moves into the victim buffer. A later read of that line completes in the cycle after the request, with `cpu_hit_o` high, the correct word, and no lower-level request.
- R6: During a victim hit, the main-array line in that slot moves into the buffer entry that was freed. A line is never held in both stores at once, and a later read of the displaced line is again served from the buffer.
- R7: A line moved into the victim buffer takes the lowest-numbered invalid entry. If all four entries are valid, it takes the entry named by a rotating pointer, which starts at 0 and then advances by one, modulo 4. The line that was overwritten is lost, and a read of it is a lower-level miss.
- R8: Every write sends one lower-level write with `mem_we_o` high. This write carries the processor address and data, and the processor write completes in the acknowledge cycle. A write that misses installs nothing, so a later read of that line is a miss that returns the written data.
- R9: A write that hits the main array updates the cached word. A later read hits there and returns the new data.
- R10: A write that hits a victim-buffer line updates that copy. A later read swaps the line back and returns the new data.
- R11: `cpu_stall_o` is high exactly when `cpu_req_i` is high and `cpu_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write word |
| cpu_rdata_o | output | 32 | Read word, valid with ready on a read |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_hit_o | output | 1 | Read completed without a lower-level access |
| cpu_stall_o | output | 1 | Request pending and not completing |
| mem_req_o | output | 1 | Lower-level request, held until acknowledge |
| mem_we_o | output | 1 | 1 = word write, 0 = line fill |
| mem_addr_o | output | 32 | Line address for fills, byte address for writes |
| mem_wdata_o | output | 32 | Write word |
| mem_ack_i | input | 1 | Lower level completes the request |
| mem_rdata_i | input | 256 | Fill line, word 0 in the low bits |

## Verification
The assertions check a set of rules in every cycle:
- A lower-level request stays steady until it is acknowledged.
- A completed hit never coincides with a lower-level request.
- No line address ever matches two victim entries.
- A pending lookup never hits both stores.
- A fill into a full buffer leaves it full.

Only the bench's scenarios show the following:
- which line the rotating pointer discards,
- that swapped lines return the right words,
- that write updates land in whichever copy holds the line.

For these, the bench runs a reference model of both stores over a long conflict-heavy access sequence.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_FILL  = 2'd2,
        ST_WRITE = 2'd3
    } vc_state_e;
endpackage

// File: rtl/vcache_vmatch.sv
// Parallel tag compare across all victim entries.
module vcache_vmatch #(
    parameter int N    = 4,
    parameter int LA_W = 27,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]           vval_i,
    input  logic [N-1:0][LA_W-1:0] vtag_i,
    input  logic [LA_W-1:0]        line_i,
    output logic [N-1:0]           match_o,
    output logic                   hit_o,
    output logic [IW-1:0]          idx_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match_o[g] = vval_i[g] && (vtag_i[g] == line_i);
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match_o[i]) idx_o = IW'(i);
        end
    end

    assign hit_o = |match_o;
endmodule

// File: rtl/vcache_vpick.sv
// Chooses the victim entry to overwrite: lowest invalid first, else pointer.
module vcache_vpick #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vval_i,
    input  logic [IW-1:0] ptr_i,
    output logic [IW-1:0] slot_o,
    output logic          full_o
);
    logic [IW-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vval_i[i]) free_idx = IW'(i);
        end
    end

    assign full_o = &vval_i;
    assign slot_o = full_o ? ptr_i : free_idx;
endmodule

// File: rtl/vcache_top.sv
module vcache_top
    import vcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 5,
    parameter int VICT_N = 4,
    localparam int LINE_W = (1 << OFF_W) * 8,
    localparam int WORDS  = LINE_W / DATA_W,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BSEL_W = $clog2(DATA_W / 8),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LA_W   = ADDR_W - OFF_W,
    localparam int SETS   = 1 << IDX_W,
    localparam int VI_W   = (VICT_N > 1) ? $clog2(VICT_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              cpu_ready_o,
    output logic              cpu_hit_o,
    output logic              cpu_stall_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [LINE_W-1:0] mem_rdata_i
);
    typedef struct packed {
        vc_state_e                   st;
        logic [ADDR_W-1:0]           addr;
        logic [DATA_W-1:0]           wdata;
        logic [VI_W-1:0]             vsel;
        logic [VI_W-1:0]             vptr;
        logic [SETS-1:0]             mval;
        logic [SETS-1:0][TAG_W-1:0]  mtag;
        logic [SETS-1:0][LINE_W-1:0] mdat;
        logic [VICT_N-1:0]           vval;
        logic [VICT_N-1:0][LA_W-1:0] vtag;
        logic [VICT_N-1:0][LINE_W-1:0] vdat;
    } vc_regs_t;

    vc_regs_t q, d;

    // Lookup address: live request when idle, latched request otherwise.
    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [LA_W-1:0]   lk_line;
    logic [WSEL_W-1:0] lk_wsel;
    logic              main_hit;

    assign lk_addr  = (q.st == ST_IDLE) ? cpu_addr_i : q.addr;
    assign lk_idx   = lk_addr[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_line  = lk_addr[ADDR_W-1:OFF_W];
    assign lk_wsel  = lk_addr[BSEL_W +: WSEL_W];
    assign main_hit = q.mval[lk_idx] && (q.mtag[lk_idx] == lk_tag);

    logic [VICT_N-1:0] v_match;
    logic              v_hit;
    logic [VI_W-1:0]   v_idx;

    vcache_vmatch #(.N(VICT_N), .LA_W(LA_W)) u_vmatch (
        .vval_i (q.vval),
        .vtag_i (q.vtag),
        .line_i (lk_line),
        .match_o(v_match),
        .hit_o  (v_hit),
        .idx_o  (v_idx)
    );

    logic [VI_W-1:0] pick_slot;
    logic            v_full;

    vcache_vpick #(.N(VICT_N)) u_vpick (
        .vval_i(q.vval),
        .ptr_i (q.vptr),
        .slot_o(pick_slot),
        .full_o(v_full)
    );

    always_comb begin
        d           = q;
        cpu_ready_o = 1'b0;
        cpu_hit_o   = 1'b0;
        cpu_rdata_o = '0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req_i) begin
                    d.addr  = cpu_addr_i;
                    d.wdata = cpu_wdata_i;
                    if (cpu_we_i) begin
                        if (main_hit)
                            d.mdat[lk_idx][lk_wsel*DATA_W +: DATA_W] = cpu_wdata_i;
                        else if (v_hit)
                            d.vdat[v_idx][lk_wsel*DATA_W +: DATA_W] = cpu_wdata_i;
                        d.st = ST_WRITE;
                    end else if (main_hit) begin
                        cpu_ready_o = 1'b1;
                        cpu_hit_o   = 1'b1;
                        cpu_rdata_o = q.mdat[lk_idx][lk_wsel*DATA_W +: DATA_W];
                    end else if (v_hit) begin
                        d.vsel = v_idx;
                        d.st   = ST_SWAP;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_SWAP: begin
                cpu_ready_o       = 1'b1;
                cpu_hit_o         = 1'b1;
                cpu_rdata_o       = q.vdat[q.vsel][lk_wsel*DATA_W +: DATA_W];
                d.mval[lk_idx]    = 1'b1;
                d.mtag[lk_idx]    = q.vtag[q.vsel][LA_W-1 -: TAG_W];
                d.mdat[lk_idx]    = q.vdat[q.vsel];
                d.vval[q.vsel]    = q.mval[lk_idx];
                d.vtag[q.vsel]    = {q.mtag[lk_idx], lk_idx};
                d.vdat[q.vsel]    = q.mdat[lk_idx];
                d.st              = ST_IDLE;
            end
            ST_FILL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {lk_line, {OFF_W{1'b0}}};
                if (mem_ack_i) begin
                    cpu_ready_o = 1'b1;
                    cpu_rdata_o = mem_rdata_i[lk_wsel*DATA_W +: DATA_W];
                    if (q.mval[lk_idx]) begin
                        d.vval[pick_slot] = 1'b1;
                        d.vtag[pick_slot] = {q.mtag[lk_idx], lk_idx};
                        d.vdat[pick_slot] = q.mdat[lk_idx];
                        if (v_full)
                            d.vptr = (q.vptr == VI_W'(VICT_N - 1)) ? '0 : q.vptr + 1'b1;
                    end
                    d.mval[lk_idx] = 1'b1;
                    d.mtag[lk_idx] = lk_tag;
                    d.mdat[lk_idx] = mem_rdata_i;
                    d.st           = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.addr;
                mem_wdata_o = q.wdata;
                if (mem_ack_i) begin
                    cpu_ready_o = 1'b1;
                    d.st        = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    assign cpu_stall_o = cpu_req_i && !cpu_ready_o;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: a lower-level request is held steady until acknowledged
    a_r4_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R3: a completed hit never involves the lower level
    a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit_o |-> !mem_req_o);

    // R5: a line address matches at most one victim entry
    a_r5_victim_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(v_match));

    // R6: a pending lookup never finds the line in both stores
    a_r6_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && cpu_req_i) |-> !(main_hit && v_hit));

    // R7: a fill into a full buffer keeps every entry valid
    a_r7_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_ack_i && v_full) |=> (&q.vval));
endmodule

// File: tb/vcache_top_tb.sv
`timescale 1ns/1ps
module vcache_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready, cpu_hit, cpu_stall;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_rdata = '0;

    int checks = 0, failures = 0, cycles = 0;
    int nrd = 0, nwr = 0, lat_cnt = 0;
    logic [31:0] last_raddr, last_waddr, last_wdata;
    logic [31:0] wmem [logic [31:0]];

    // reference model of both stores (line addresses)
    logic        mv [32];
    logic [26:0] mt [32];
    logic        vv [4];
    logic [26:0] vl [4];
    int          vp = 0;

    always #5 clk = ~clk;

    vcache_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
        .cpu_hit_o(cpu_hit), .cpu_stall_o(cpu_stall),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (wmem.exists(w)) return wmem[w];
        return {w[15:0], w[15:0] ^ 16'h5A3C};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // lower-level responder: answers two cycles after a request appears
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat_cnt = 0;
            end else if (mem_req) begin
                lat_cnt++;
                if (lat_cnt == 2) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        nwr++;
                        last_waddr = mem_addr;
                        last_wdata = mem_wdata;
                        wmem[{mem_addr[31:2], 2'b00}] = mem_wdata;
                    end else begin
                        nrd++;
                        last_raddr = mem_addr;
                        for (int w = 0; w < 8; w++)
                            mem_rdata[w*32 +: 32] = memval({mem_addr[31:5], 3'(w), 2'b00});
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output bit hit, output int cyc, output bit stall_ok);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0; stall_ok = 1'b1;
        forever begin
            #1;
            if (cpu_stall != !cpu_ready) stall_ok = 1'b0;
            if (cpu_ready) begin
                rd = cpu_rdata; hit = cpu_hit;
                @(posedge clk); #1;
                cpu_req = 1'b0;
                break;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    // model: 0 = main hit, 1 = victim swap, 2 = fill
    function automatic int predict(input logic [26:0] la);
        int idx, slot;
        logic tv; logic [26:0] tl;
        idx = int'(la[4:0]);
        if (mv[idx] && mt[idx] == la) return 0;
        for (int v = 0; v < 4; v++) begin
            if (vv[v] && vl[v] == la) begin
                tv = mv[idx]; tl = mt[idx];
                mv[idx] = 1'b1; mt[idx] = la;
                vv[v] = tv; vl[v] = tl;
                return 1;
            end
        end
        if (mv[idx]) begin
            slot = -1;
            for (int v = 3; v >= 0; v--) if (!vv[v]) slot = v;
            if (slot < 0) begin
                slot = vp;
                vp = (vp + 1) % 4;
            end
            vv[slot] = 1'b1; vl[slot] = mt[idx];
        end
        mv[idx] = 1'b1; mt[idx] = la;
        return 2;
    endfunction

    task automatic do_read(input logic [31:0] a, input string req);
        logic [31:0] rd; bit hit, sok; int cyc, kind, akind, rd0;
        kind = predict(a[31:5]);
        rd0 = nrd;
        access(1'b0, a, 32'h0, rd, hit, cyc, sok);
        if (nrd - rd0 == 1 && !hit) akind = 2;
        else if (nrd == rd0 && hit && cyc == 0) akind = 0;
        else if (nrd == rd0 && hit && cyc == 1) akind = 1;
        else akind = 3;
        check(akind == kind, req, akind, kind);
        check(rd == memval(a), req, rd, memval(a));
        if (kind == 2) check(last_raddr == {a[31:5], 5'b0}, "R2 fill address", last_raddr, {a[31:5], 5'b0});
        check(sok, "R11 stall", {31'b0, sok}, 32'd1);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] wd, input string req);
        logic [31:0] rd; bit hit, sok; int cyc, w0, r0;
        w0 = nwr; r0 = nrd;
        access(1'b1, a, wd, rd, hit, cyc, sok);
        check(nwr - w0 == 1 && nrd == r0, req, nwr - w0, 1);
        check(last_waddr == a && last_wdata == wd, req, last_wdata, wd);
        check(sok, "R11 stall", {31'b0, sok}, 32'd1);
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int word);
        return {22'(tag), 5'(idx), 3'(word), 2'b00};
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) begin mv[i] = 0; mt[i] = '0; end
        for (int i = 0; i < 4; i++) begin vv[i] = 0; vl[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_ready && !cpu_stall && !mem_req, "R1 idle after reset",
              {29'b0, cpu_ready, cpu_stall, mem_req}, 32'd0);
        // R1/R4: cold miss, then R3 hit in another word of the same line (R2 word select)
        do_read(mk(1, 3, 0), "R1 cold miss");
        do_read(mk(1, 3, 5), "R3 main hit");
        do_read(mk(2, 3, 5), "R2 same index new tag");
        // R5/R6: swap back and forth
        do_read(mk(1, 3, 7), "R5 victim hit");
        do_read(mk(2, 3, 1), "R6 displaced line swap");
        do_read(mk(2, 3, 1), "R3 hit after swap");
        // R7: six conflicting lines on index 9
        for (int t = 0; t < 6; t++) do_read(mk(10 + t, 9, t), "R7 fill");
        do_read(mk(10, 9, 0), "R7 oldest dropped");
        do_read(mk(12, 9, 2), "R7 survivor");
        // R8: write miss, then read returns written value
        do_write(mk(40, 20, 3), 32'hC0DE0001, "R8 write miss");
        do_read(mk(40, 20, 3), "R8 read after write miss");
        // R9: write hit in main
        do_write(mk(40, 20, 3), 32'hC0DE0002, "R9 write hit");
        do_read(mk(40, 20, 3), "R9 read new data");
        // R10: write hit in victim copy
        do_read(mk(41, 20, 0), "R10 push line to buffer");
        do_write(mk(40, 20, 6), 32'hC0DE0003, "R10 write victim copy");
        do_read(mk(40, 20, 6), "R10 swap returns new data");
        // near-exhaustive conflict sweep over two indices and seven tags
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = mk(100 + (i * 5) % 7, 16 + (i % 2), (i * 3) % 8);
            if (i % 6 == 5) do_write(a, 32'hBEEF0000 | i, "R8 sweep write");
            else            do_read(a, "R4 sweep read");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule